// File: doc/BRIEF.md
# Channel-Addressed ADC Conversion Sequencer

This block sits on an 8-bit register bus and drives one multiplexed 12-bit analog-to-digital converter. Software writes a channel number to the channel register, and that write is the only start command. The sequencer latches the channel onto the multiplexer select lines and waits out a settling interval whose length depends on the amplifier gain range. It then puts the sample-and-hold into hold and fires a one-cycle start strobe to the converter. The result is captured when the converter's busy line falls.

The result is read as two bytes. A status register reports whether a sequence is running and whether a finished result is still waiting to be read. An interrupt request, gated by an enable bit, flags each completion and stays up until software reads the high result byte. The settling interval is counted in system clocks, and the number of clocks per microsecond is a parameter.

Register map on the 3-bit `bus_addr`: 0 channel (write), 1 status (read), 2 result low byte, 3 result high byte, 4 control (read/write). Any other address reads 0.

Top module: `adc_seq`

## Requirements
- R1: After reset the status register reads 0x03, and `irq`, `sh_hold` and `adc_start` are 0.
- R2: A write to address 0 while idle drives `wdata[4:0]` onto `mux_ch` from the next cycle on and starts a sequence.
- R3: The settle interval, counted in cycles from the write edge to the edge that raises `adc_start`, is CLK_MHZ times 20, 30, 40 or 100 for gain codes 0, 1, 2 and 3 (control bits 1:0). The gain code is taken as it stands at the channel write.
- R4: `adc_start` is high for exactly one cycle, in the same cycle that `sh_hold` rises. `sh_hold` stays high until the cycle after busy is sampled low.
- R5: Status bit 0 reads 0 from the cycle after the channel write until the cycle after `adc_busy` is sampled low following the start. It reads 1 at all other times.
- R6: Status bit 1 falls to 0 on completion. It returns to 1 only once both result bytes (address 2 and address 3, in either order) have been read. Reading only one of them leaves it at 0.
- R7: Address 2 reads result bits 7:0. Address 3 reads {4'b0, result bits 11:8}.
- R8: Status bits 7:2 always read 0.
- R9: A channel write during a running sequence is ignored. `mux_ch`, the settle timing and the captured result are unaffected, and no second start strobe is issued.
- R10: When control bit 2 (interrupt enable) is 1, `irq` rises on completion and stays high until address 3 is read. When the enable bit is 0, `irq` stays 0.
- R11: Address 4 reads back {5'b0, enable, gain}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from bus_addr |
| mux_ch | output | 5 | Latched analog channel select |
| sh_hold | output | 1 | Sample-and-hold in hold mode |
| adc_start | output | 1 | One-cycle start-of-conversion strobe |
| adc_busy | input | 1 | Converter busy |
| adc_data | input | 12 | Converter result, valid when busy falls |
| irq | output | 1 | Data-ready interrupt request |

## Verification
A sequencer stuck in the wrong phase shows up at once in status bit 0, and in the settle count measured between the channel write and the start strobe, which must match the cycle count for that gain code exactly. A lost or stale read-tracking flag shows up on the next status read after a single result-byte read, or as an interrupt line that fails to drop on the high-byte read. The bench sweeps every channel under every gain code, so a channel or gain decode fault appears in the very conversion that uses the value.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CLK_MHZ = 100,
  parameter int CH_W    = 5,
  parameter int RES_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [CH_W-1:0]  mux_ch,
  output logic             sh_hold,
  output logic             adc_start,
  input  logic             adc_busy,
  input  logic [RES_W-1:0] adc_data,
  output logic             irq
);
  localparam int MAX_CYC = CLK_MHZ * 100;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int HI_W    = RES_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_ARM, S_CONV} state_t;

  state_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [CH_W-1:0]    ch_q;
  logic [1:0]         gain_q;
  logic               ien_q;
  logic [RES_W-1:0]   res_q;
  logic               unread_q, lo_seen, hi_seen, irq_q;
  logic               start_q, hold_q;
  logic               active, wr_ch, wr_ctl, rd_lo, rd_hi, lo_n, hi_n;
  logic               unused_bits;

  function automatic logic [CNT_W-1:0] settle_len(input logic [1:0] g);
    case (g)
      2'd0:    settle_len = CNT_W'(CLK_MHZ * 20);
      2'd1:    settle_len = CNT_W'(CLK_MHZ * 30);
      2'd2:    settle_len = CNT_W'(CLK_MHZ * 40);
      default: settle_len = CNT_W'(CLK_MHZ * 100);
    endcase
  endfunction

  assign active  = (st != S_IDLE);
  assign wr_ch   = wr_en && bus_addr == 3'd0;
  assign wr_ctl  = wr_en && bus_addr == 3'd4;
  assign rd_lo   = rd_en && bus_addr == 3'd2;
  assign rd_hi   = rd_en && bus_addr == 3'd3;
  assign lo_n    = lo_seen | rd_lo;
  assign hi_n    = hi_seen | rd_hi;
  assign unused_bits = ^wdata[7:5];

  assign mux_ch    = ch_q;
  assign sh_hold   = hold_q;
  assign adc_start = start_q;
  assign irq       = irq_q & ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_ctl) begin
      gain_q <= wdata[1:0];
      ien_q  <= wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ch_q     <= '0;
      res_q    <= '0;
      unread_q <= 1'b0;
      lo_seen  <= 1'b0;
      hi_seen  <= 1'b0;
      irq_q    <= 1'b0;
      start_q  <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      lo_seen <= lo_n;
      hi_seen <= hi_n;
      if (lo_n && hi_n) unread_q <= 1'b0;
      if (rd_hi) irq_q <= 1'b0;
      case (st)
        S_IDLE: if (wr_ch) begin
          ch_q <= wdata[CH_W-1:0];
          cnt  <= settle_len(gain_q) - 1'b1;
          st   <= S_SETTLE;
        end
        S_SETTLE: if (cnt == '0) begin
          st      <= S_ARM;
          start_q <= 1'b1;
          hold_q  <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_ARM: if (adc_busy) st <= S_CONV;
        default: if (!adc_busy) begin
          st       <= S_IDLE;
          hold_q   <= 1'b0;
          res_q    <= adc_data;
          unread_q <= 1'b1;
          lo_seen  <= 1'b0;
          hi_seen  <= 1'b0;
          irq_q    <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      3'd1:    rdata = {6'b0, ~unread_q, ~active};
      3'd2:    rdata = res_q[7:0];
      3'd3:    rdata = {{(8-HI_W){1'b0}}, res_q[RES_W-1:8]};
      3'd4:    rdata = {5'b0, ien_q, gain_q};
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      bus_addr,
  input logic [7:0]      rdata,
  input logic [CH_W-1:0] mux_ch,
  input logic            sh_hold,
  input logic            adc_start,
  input logic            adc_busy,
  input logic            irq,
  input logic            active,
  input logic            ien
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R4
  AST_START_WITH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (sh_hold && !$past(sh_hold))); // R4
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && adc_busy) |-> sh_hold); // R4
  AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1) |-> (rdata[7:2] == 6'd0)); // R8
  AST_CH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(mux_ch)); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien); // R10
endmodule

bind adc_seq adc_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rdata(rdata),
  .mux_ch(mux_ch), .sh_hold(sh_hold), .adc_start(adc_start),
  .adc_busy(adc_busy), .irq(irq), .active(active), .ien(ien_q)
);

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int MHZ = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = 3'd1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [4:0]  mux_ch;
  logic        sh_hold, adc_start, irq;
  logic        adc_busy = 1'b0;
  logic [11:0] adc_data = 12'h000;
  int total = 0, bad = 0;
  int cur_gain = 0;

  always #5 clk = ~clk;

  adc_seq #(.CLK_MHZ(MHZ)) u_adc_seq (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .mux_ch(mux_ch), .sh_hold(sh_hold),
    .adc_start(adc_start), .adc_busy(adc_busy), .adc_data(adc_data), .irq(irq)
  );

  function automatic logic [11:0] conv_val(input int ch, input int g);
    conv_val = 12'((ch * 131 + g * 517 + 9) % 4096);
  endfunction

  function automatic int settle_of(input int g);
    settle_of = MHZ * ((g == 0) ? 20 : (g == 1) ? 30 : (g == 2) ? 40 : 100);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bus_addr = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0; bus_addr = 3'd1;
    #1;
  endtask

  // converter model: value depends on the channel presented at start
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        logic [11:0] v;
        int lat;
        v = conv_val(int'(mux_ch), cur_gain);
        lat = 3 + int'(mux_ch) % 4;
        adc_busy = 1'b1;
        repeat (lat) @(negedge clk);
        adc_data = v;
        adc_busy = 1'b0;
      end
    end
  end

  // waits for idle; returns number of start strobes seen
  task automatic wait_done(output int starts);
    int guard = 0;
    bit hold_seen = 0;
    starts = 0;
    bus_addr = 3'd1;
    #1;
    while (rdata[0] == 1'b0 && guard < 2000) begin
      if (adc_busy && !hold_seen) begin
        hold_seen = 1;
        chk("R4 hold during busy", int'(sh_hold), 1);
      end
      @(negedge clk); #1;
      if (adc_start) starts++;
      guard++;
    end
    chk("R5 status bit0 back to 1", int'(rdata[0]), 1);
    chk("R4 hold released", int'(sh_hold), 0);
  endtask

  task automatic convert(input int ch, input int g, input bit ien);
    logic [7:0] d;
    int n, starts;
    logic [11:0] e;
    e = conv_val(ch, g);
    cur_gain = g;
    wr(3'd0, 8'(ch));
    #1;
    chk("R2 mux_ch latched", int'(mux_ch), ch);
    chk("R5 status bit0 low in settle", int'(rdata[0]), 0);
    n = 0;
    while (!adc_start && n < 1000) begin
      @(negedge clk); #1;
      n++;
    end
    chk("R3 settle cycles", n, settle_of(g));
    chk("R4 hold rises with start", int'(sh_hold), 1);
    @(negedge clk); #1;
    chk("R4 start one cycle", int'(adc_start), 0);
    wait_done(starts);
    chk("R6 status after completion", int'(rdata), 8'h01);
    chk("R10 irq on completion", int'(irq), int'(ien));
    if (ch % 2 == 0) begin
      rd(3'd2, d); chk("R7 low byte", int'(d), int'(e[7:0]));
      chk("R6 one byte read keeps bit1 low", int'(rdata), 8'h01);
      rd(3'd3, d); chk("R7 high byte", int'(d), int'(e[11:8]));
    end else begin
      rd(3'd3, d); chk("R7 high byte", int'(d), int'(e[11:8]));
      chk("R6 one byte read keeps bit1 low", int'(rdata), 8'h01);
      chk("R10 irq cleared by high read", int'(irq), 0);
      rd(3'd2, d); chk("R7 low byte", int'(d), int'(e[7:0]));
    end
    chk("R6 both bytes read", int'(rdata), 8'h03);
    chk("R10 irq low after reads", int'(irq), 0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int starts;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 status at reset", int'(rdata), 8'h03);
    chk("R1 irq at reset", int'(irq), 0);
    chk("R1 hold at reset", int'(sh_hold), 0);
    chk("R1 start at reset", int'(adc_start), 0);
    rd(3'd1, d);
    chk("R8 status pad bits", int'(d[7:2]), 0);

    for (int g = 0; g < 4; g++) begin
      bit en;
      en = (g % 2 == 0);
      wr(3'd4, {5'b0, en, 2'(g)});
      rd(3'd4, d);
      chk("R11 control readback", int'(d), int'({5'b0, en, 2'(g)}));
      for (int ch = 0; ch < 32; ch++) convert(ch, g, en);
    end

    // R9: second channel write during settle is ignored
    wr(3'd4, 8'h04);
    cur_gain = 0;
    wr(3'd0, 8'd5);
    @(negedge clk);
    wr(3'd0, 8'd9);
    #1;
    chk("R9 mux_ch unchanged", int'(mux_ch), 5);
    wait_done(starts);
    chk("R9 single start strobe", starts, 1);
    rd(3'd2, d); chk("R9 result of first channel low", int'(d), int'(conv_val(5, 0) & 12'hFF));
    rd(3'd3, d); chk("R9 result of first channel high", int'(d), int'(conv_val(5, 0) >> 8));
    chk("R8 status pad bits", int'(rdata[7:2]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule